// File: doc/BRIEF.md
# Ring Replicated-Memory Node Datapath

This block is the packet path of one node on a one-way ring of nodes that keep identical copies of a shared memory. Every local write the host makes to its memory is also snooped into a local transmit queue. A packetizer gathers runs of consecutive word addresses into packets of 1 to `MAX_WORDS` 32-bit words (4 to 64 bytes by default) and sends them to the next node. Packets that arrive from the upstream node are written into local memory at the same word address they carried at their origin. In the same cycle they are queued for forwarding downstream.

A packet that comes back to the node that sent it is removed from the ring and raises a sticky indicator. A node may also hold one or both of the two rogue-master roles. In that case it stamps its role's marker bit on every header it sends. A packet that reaches it already carrying that marker has gone around the ring twice without being claimed. Such a packet is dropped, and a fault flag is raised that can request an interrupt.

The ring streams move 34-bit flits, one per cycle, with no back-pressure. A packet is one header flit followed by one or more data flits, and the final data flit is marked last. The header word holds the sender ID in bits [7:0], the role-0 marker in bit 8, the role-1 marker in bit 9, and the first word address in bits [31:10]. The address is zero-extended from `ADDR_W` bits.

Top module: `rnode_top`

## Requirements
- R1: A host write is transmitted in a packet whose header carries `myId` in bits [7:0] and the write's word address in bits [31:10]. The write data follows in data flits, in the order the writes were made.
- R2: A packet grows while the next queued write has the next word address, and it ends at `MAX_WORDS` data words. A non-contiguous or missing next entry ends the packet, so one word is the smallest packet.
- R3: Each data word of a packet whose sender ID differs from `myId` and that is not dropped under R7 produces one memory write. Word k of the packet goes to the header address plus k.
- R4: Such a packet is forwarded on the transmit stream with its flit count, data and last marking unchanged.
- R5: A packet whose sender ID equals `myId` is neither written to memory nor forwarded. It sets `ownSeen`, which stays set until reset.
- R6: Every transmitted header, whether local or forwarded, has bit 8 set when `rogueRole[0]` is 1 and bit 9 set when `rogueRole[1]` is 1. A forwarded header otherwise keeps its incoming marker bits.
- R7: A foreign packet whose header has a marker bit set for a role this node holds is dropped, with no memory write and no forwarding, and it sets `rogueFault`.
- R8: A one-cycle `rogueClr` pulse clears `rogueFault`, unless a new fault is detected in the same cycle. `irq` is high exactly while `rogueFault` and `irqEn` are both high.
- R9: When the transmitter is free and forwarded flits are waiting, the forwarded packet is sent before any local packet. A local packet already being sent is never interrupted.
- R10: After reset, `txValid`, `memWrEn`, `ownSeen`, `rogueFault` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| myId | input | 8 | This node's ring ID |
| rogueRole | input | 2 | Rogue-master roles held: bit 0 is role 0, bit 1 is role 1 |
| hostWrEn | input | 1 | Snooped host memory write strobe |
| hostAddr | input | ADDR_W | Word address of the host write |
| hostData | input | 32 | Data of the host write |
| rxValid | input | 1 | Incoming flit valid |
| rxHead | input | 1 | Incoming flit is a header |
| rxLast | input | 1 | Incoming flit is the final data flit |
| rxData | input | 32 | Incoming flit payload |
| rogueClr | input | 1 | Clear pulse for the rogue fault flag |
| irqEn | input | 1 | Interrupt enable for the rogue fault |
| memWrEn | output | 1 | Memory write strobe for received data |
| memAddr | output | ADDR_W | Memory word address |
| memData | output | 32 | Memory write data |
| txValid | output | 1 | Outgoing flit valid |
| txHead | output | 1 | Outgoing flit is a header |
| txLast | output | 1 | Outgoing flit is the final data flit |
| txData | output | 32 | Outgoing flit payload |
| ownSeen | output | 1 | Sticky: one of this node's packets has returned |
| rogueFault | output | 1 | Rogue packet detected |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a correct environment. The host never writes while the local queue is full, and the upstream node never offers a flit while the forward queue is full. The roles are also assumed not to change while a packet is queued or in flight. The directed stimulus keeps both queues shallow by leaving idle cycles between packets. It changes `myId`, `rogueRole` and `irqEn` only after all queued traffic has drained. Received packets are always well formed: a header followed by data flits, with the final one marked last.

// File: rtl/rnode_pkg.sv
package rnode_pkg;
  localparam int DATA_W       = 32;
  localparam int ID_W         = 8;
  localparam int HDR_MARK_LSB = 8;
  localparam int HDR_ADDR_LSB = 10;

  typedef struct packed {
    logic              head;
    logic              last;
    logic [DATA_W-1:0] data;
  } flit_t;

  typedef enum logic [1:0] {SRC_NONE, SRC_FWD, SRC_LHDR, SRC_LDATA} txSrc_e;

  typedef struct packed {
    logic   fwdPush;
    logic   setMarks;
    logic   memWr;
    logic   loadAddr;
    logic   txLoad;
    txSrc_e txSel;
    logic   locLast;
  } strobe_t;
endpackage

// File: rtl/rnode_fifo.sv
module rnode_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     push,
  input  logic [W-1:0]             din,
  input  logic                     pop,
  output logic [W-1:0]             dout,
  output logic [W-1:0]             dnext,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     full,
  output logic                     empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= AW'(wrPtr + 1'b1);
      if (pop)  rdPtr <= AW'(rdPtr + 1'b1);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout  = mem[rdPtr];
  assign dnext = mem[AW'(rdPtr + 1'b1)];
  assign full  = (count == DEPTH[AW:0]);
  assign empty = (count == '0);
endmodule

// File: rtl/rnode_ctrl.sv
module rnode_ctrl
  import rnode_pkg::*;
#(
  parameter int MAX_WORDS = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [ID_W-1:0] myId,
  input  logic [1:0]      rogueRole,
  input  logic            rxValid,
  input  logic            rxHead,
  input  logic [9:0]      rxTag,
  input  logic            rogueClr,
  input  logic            irqEn,
  input  logic            lqEmpty,
  input  logic            lqRunBreak,
  input  logic            fqEmpty,
  input  logic            fqHeadLast,
  output strobe_t         stb,
  output logic            ownSeen,
  output logic            rogueFault,
  output logic            irq
);
  localparam int CW = $clog2(MAX_WORDS);

  typedef enum logic [1:0] {M_IDLE, M_FWD, M_LOC} txMode_e;

  txMode_e       mode, modeNxt;
  logic [CW-1:0] wordCnt, wordCntNxt;
  logic          rxDrop;
  logic          hdrOwn, hdrRogue, dropNow, hdrSeen;

  // receive-side classification of the header flit
  assign hdrSeen  = rxValid && rxHead;
  assign hdrOwn   = (rxTag[ID_W-1:0] == myId);
  assign hdrRogue = |(rxTag[9:8] & rogueRole) && !hdrOwn;
  assign dropNow  = hdrOwn || hdrRogue;

  always_comb begin
    stb          = '0;
    stb.fwdPush  = rxValid && (rxHead ? !dropNow : !rxDrop);
    stb.setMarks = rxHead;
    stb.memWr    = rxValid && !rxHead && !rxDrop;
    stb.loadAddr = hdrSeen;
    stb.locLast  = lqRunBreak || (wordCnt == CW'(MAX_WORDS - 1));
    stb.txSel    = SRC_NONE;
    modeNxt      = mode;
    wordCntNxt   = wordCnt;
    case (mode)
      M_IDLE: begin
        if (!fqEmpty) begin
          stb.txLoad = 1'b1;
          stb.txSel  = SRC_FWD;
          modeNxt    = M_FWD;
        end else if (!lqEmpty) begin
          stb.txLoad = 1'b1;
          stb.txSel  = SRC_LHDR;
          modeNxt    = M_LOC;
          wordCntNxt = '0;
        end
      end
      M_FWD: begin
        if (!fqEmpty) begin
          stb.txLoad = 1'b1;
          stb.txSel  = SRC_FWD;
          if (fqHeadLast) modeNxt = M_IDLE;
        end
      end
      M_LOC: begin
        stb.txLoad = 1'b1;
        stb.txSel  = SRC_LDATA;
        wordCntNxt = CW'(wordCnt + 1'b1);
        if (stb.locLast) modeNxt = M_IDLE;
      end
      default: modeNxt = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode       <= M_IDLE;
      wordCnt    <= '0;
      rxDrop     <= 1'b0;
      ownSeen    <= 1'b0;
      rogueFault <= 1'b0;
    end else begin
      mode    <= modeNxt;
      wordCnt <= wordCntNxt;
      if (hdrSeen) rxDrop <= dropNow;
      ownSeen    <= ownSeen || (hdrSeen && hdrOwn);
      rogueFault <= (hdrSeen && hdrRogue) || (rogueFault && !rogueClr);
    end
  end

  assign irq = rogueFault && irqEn;
endmodule

// File: rtl/rnode_dpath.sv
module rnode_dpath
  import rnode_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int LQ_DEPTH = 32,
  parameter int FQ_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ID_W-1:0]   myId,
  input  logic [1:0]        rogueRole,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostData,
  input  logic              rxHead,
  input  logic              rxLast,
  input  logic [DATA_W-1:0] rxData,
  input  strobe_t           stb,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              txValid,
  output logic              txHead,
  output logic              txLast,
  output logic [DATA_W-1:0] txData,
  output logic              lqEmpty,
  output logic              lqRunBreak,
  output logic              lqFull,
  output logic              fqEmpty,
  output logic              fqHeadLast,
  output logic              fqFull
);
  localparam int LW = ADDR_W + DATA_W;

  logic [LW-1:0]             lqHead, lqNext;
  logic [$clog2(LQ_DEPTH):0] lqCount;
  logic [$clog2(FQ_DEPTH):0] fqCount;
  flit_t                     fqIn, fqHead, unusedFqNext;
  logic [ADDR_W-1:0]         curAddr;
  logic [DATA_W-1:0]         markBits, locHdr;
  logic [ADDR_W-1:0]         headAddr, nextAddr;

  rnode_fifo #(.W(LW), .DEPTH(LQ_DEPTH)) u_locQ (
    .clk(clk), .rstN(rstN),
    .push(hostWrEn), .din({hostAddr, hostData}),
    .pop(stb.txLoad && stb.txSel == SRC_LDATA),
    .dout(lqHead), .dnext(lqNext), .count(lqCount),
    .full(lqFull), .empty(lqEmpty)
  );

  assign markBits = DATA_W'(rogueRole) << HDR_MARK_LSB;
  assign fqIn.head = rxHead;
  assign fqIn.last = rxLast;
  assign fqIn.data = stb.setMarks ? (rxData | markBits) : rxData;

  rnode_fifo #(.W($bits(flit_t)), .DEPTH(FQ_DEPTH)) u_fwdQ (
    .clk(clk), .rstN(rstN),
    .push(stb.fwdPush), .din(fqIn),
    .pop(stb.txLoad && stb.txSel == SRC_FWD),
    .dout(fqHead), .dnext(unusedFqNext), .count(fqCount),
    .full(fqFull), .empty(fqEmpty)
  );

  assign fqHeadLast = fqHead.last;
  assign headAddr   = lqHead[LW-1:DATA_W];
  assign nextAddr   = lqNext[LW-1:DATA_W];
  assign lqRunBreak = (lqCount < 2) || (nextAddr != ADDR_W'(headAddr + 1'b1));
  assign locHdr     = (DATA_W'(headAddr) << HDR_ADDR_LSB) | markBits | DATA_W'(myId);

  // memory update path for received words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      memWrEn <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      memWrEn <= stb.memWr;
      if (stb.loadAddr) curAddr <= ADDR_W'(rxData[DATA_W-1:HDR_ADDR_LSB]);
      if (stb.memWr) begin
        memAddr <= curAddr;
        memData <= rxData;
        curAddr <= ADDR_W'(curAddr + 1'b1);
      end
    end
  end

  // transmit register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txHead  <= 1'b0;
      txLast  <= 1'b0;
      txData  <= '0;
    end else begin
      txValid <= stb.txLoad;
      case (stb.txSel)
        SRC_FWD:   {txHead, txLast, txData} <= fqHead;
        SRC_LHDR:  {txHead, txLast, txData} <= {1'b1, 1'b0, locHdr};
        SRC_LDATA: {txHead, txLast, txData} <= {1'b0, stb.locLast, lqHead[DATA_W-1:0]};
        default:   {txHead, txLast, txData} <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rnode_top.sv
module rnode_top
  import rnode_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MAX_WORDS = 16,
  parameter int LQ_DEPTH  = 32,
  parameter int FQ_DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        myId,
  input  logic [1:0]        rogueRole,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostData,
  input  logic              rxValid,
  input  logic              rxHead,
  input  logic              rxLast,
  input  logic [31:0]       rxData,
  input  logic              rogueClr,
  input  logic              irqEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memData,
  output logic              txValid,
  output logic              txHead,
  output logic              txLast,
  output logic [31:0]       txData,
  output logic              ownSeen,
  output logic              rogueFault,
  output logic              irq
);
  strobe_t stb;
  logic    lqEmpty, lqRunBreak, lqFull, fqEmpty, fqHeadLast, fqFull;

  rnode_ctrl #(.MAX_WORDS(MAX_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .myId(myId), .rogueRole(rogueRole),
    .rxValid(rxValid), .rxHead(rxHead), .rxTag(rxData[9:0]),
    .rogueClr(rogueClr), .irqEn(irqEn),
    .lqEmpty(lqEmpty), .lqRunBreak(lqRunBreak),
    .fqEmpty(fqEmpty), .fqHeadLast(fqHeadLast),
    .stb(stb), .ownSeen(ownSeen), .rogueFault(rogueFault), .irq(irq)
  );

  rnode_dpath #(.ADDR_W(ADDR_W), .LQ_DEPTH(LQ_DEPTH), .FQ_DEPTH(FQ_DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .myId(myId), .rogueRole(rogueRole),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostData(hostData),
    .rxHead(rxHead), .rxLast(rxLast), .rxData(rxData), .stb(stb),
    .memWrEn(memWrEn), .memAddr(memAddr), .memData(memData),
    .txValid(txValid), .txHead(txHead), .txLast(txLast), .txData(txData),
    .lqEmpty(lqEmpty), .lqRunBreak(lqRunBreak), .lqFull(lqFull),
    .fqEmpty(fqEmpty), .fqHeadLast(fqHeadLast), .fqFull(fqFull)
  );
endmodule

// File: rtl/rnode_checker.sv
module rnode_checker (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  rogueRole,
  input logic        hostWrEn,
  input logic        lqFull,
  input logic        rxValid,
  input logic        rxHead,
  input logic [31:0] rxData,
  input logic        fqFull,
  input logic        rogueClr,
  input logic        memWrEn,
  input logic        txValid,
  input logic        txHead,
  input logic [31:0] txData,
  input logic        ownSeen,
  input logic        rogueFault
);
  // R1: environment never writes into a full local queue
  p_lq_room_r1: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn |-> !lqFull);

  // R4: upstream never offers a flit the forward queue cannot hold
  p_fq_room_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !fqFull);

  // R3: every memory write follows a received data flit
  p_mem_src_r3: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(rxValid && !rxHead));

  // R5: the own-data indicator is sticky
  p_own_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    ownSeen |=> ownSeen);

  // R6: held roles are stamped on every outgoing header
  p_mark_r6: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txHead) |-> ((txData[9:8] & rogueRole) == rogueRole));

  // R7: a new fault needs a marked header for a held role
  p_fault_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rogueFault) |-> $past(rxValid && rxHead && (|(rxData[9:8] & rogueRole))));

  // R8: a clear without a concurrent detection empties the flag
  p_fault_clr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rogueFault && rogueClr && !(rxValid && rxHead)) |=> !rogueFault);
endmodule

bind rnode_top rnode_checker u_chk (
  .clk(clk), .rstN(rstN), .rogueRole(rogueRole),
  .hostWrEn(hostWrEn), .lqFull(lqFull),
  .rxValid(rxValid), .rxHead(rxHead), .rxData(rxData), .fqFull(fqFull),
  .rogueClr(rogueClr), .memWrEn(memWrEn),
  .txValid(txValid), .txHead(txHead), .txData(txData),
  .ownSeen(ownSeen), .rogueFault(rogueFault)
);

// File: tb/test_rnode_top.sv
module test_rnode_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  myId = 8'h21;
  logic [1:0]  rogueRole = 2'b00;
  logic        hostWrEn = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [31:0] hostData = '0;
  logic        rxValid = 1'b0, rxHead = 1'b0, rxLast = 1'b0;
  logic [31:0] rxData = '0;
  logic        rogueClr = 1'b0, irqEn = 1'b0;
  logic        memWrEn, txValid, txHead, txLast, ownSeen, rogueFault, irq;
  logic [15:0] memAddr;
  logic [31:0] memData, txData;

  int checks = 0;
  int errors = 0;

  logic [33:0] txLog[$], expTx[$];
  logic [47:0] memLog[$], expMem[$];

  always #10 clk = ~clk;

  rnode_top i_rnode_top (
    .clk(clk), .rstN(rstN), .myId(myId), .rogueRole(rogueRole),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostData(hostData),
    .rxValid(rxValid), .rxHead(rxHead), .rxLast(rxLast), .rxData(rxData),
    .rogueClr(rogueClr), .irqEn(irqEn),
    .memWrEn(memWrEn), .memAddr(memAddr), .memData(memData),
    .txValid(txValid), .txHead(txHead), .txLast(txLast), .txData(txData),
    .ownSeen(ownSeen), .rogueFault(rogueFault), .irq(irq)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (txValid) txLog.push_back({txHead, txLast, txData});
      if (memWrEn) memLog.push_back({memAddr, memData});
    end
  end

  task automatic expEq(string req, string what, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] hdrWord(logic [15:0] a, logic [7:0] s, logic [1:0] m);
    return {6'b0, a, m, s};
  endfunction

  task automatic expPkt(logic [7:0] s, logic [1:0] m, logic [15:0] a, int n,
                        logic [31:0] base, bit toMem);
    expTx.push_back({1'b1, 1'b0, hdrWord(a, s, m)});
    for (int i = 0; i < n; i++) begin
      expTx.push_back({1'b0, (i == n - 1), base + 32'(i)});
      if (toMem) expMem.push_back({a + 16'(i), base + 32'(i)});
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostBurst(logic [15:0] a, int n, logic [31:0] base, int stride);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hostWrEn = 1'b1;
      hostAddr = a + 16'(i * stride);
      hostData = base + 32'(i);
    end
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic rxPacket(logic [7:0] s, logic [1:0] m, logic [15:0] a, int n,
                          logic [31:0] base);
    @(negedge clk);
    rxValid = 1'b1; rxHead = 1'b1; rxLast = 1'b0; rxData = hdrWord(a, s, m);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxHead = 1'b0; rxLast = (i == n - 1); rxData = base + 32'(i);
    end
    @(negedge clk);
    rxValid = 1'b0; rxHead = 1'b0; rxLast = 1'b0;
  endtask

  task automatic cmpLogs(string req);
    expEq(req, "tx flit count", 48'(txLog.size()), 48'(expTx.size()));
    for (int i = 0; i < txLog.size() && i < expTx.size(); i++)
      expEq(req, $sformatf("tx flit %0d", i), 48'(txLog[i]), 48'(expTx[i]));
    expEq(req, "mem write count", 48'(memLog.size()), 48'(expMem.size()));
    for (int i = 0; i < memLog.size() && i < expMem.size(); i++)
      expEq(req, $sformatf("mem write %0d", i), memLog[i], expMem[i]);
    txLog.delete(); expTx.delete(); memLog.delete(); expMem.delete();
  endtask

  // R10: reset state
  task automatic tReset();
    @(negedge clk);
    expEq("R10", "txValid", 48'(txValid), 48'd0);
    expEq("R10", "memWrEn", 48'(memWrEn), 48'd0);
    expEq("R10", "ownSeen", 48'(ownSeen), 48'd0);
    expEq("R10", "rogueFault", 48'(rogueFault), 48'd0);
    expEq("R10", "irq", 48'(irq), 48'd0);
  endtask

  // R1 R2: local packetization
  task automatic tLocal();
    hostBurst(16'h0100, 3, 32'hA000_0000, 1);
    hostBurst(16'h0200, 1, 32'hA100_0000, 1);
    idle(20);
    expPkt(8'h21, 2'b00, 16'h0100, 3, 32'hA000_0000, 0);
    expPkt(8'h21, 2'b00, 16'h0200, 1, 32'hA100_0000, 0);
    cmpLogs("R1");
    hostBurst(16'h0300, 18, 32'hA200_0000, 1);
    idle(30);
    expPkt(8'h21, 2'b00, 16'h0300, 16, 32'hA200_0000, 0);
    expPkt(8'h21, 2'b00, 16'h0310, 2, 32'hA200_0010, 0);
    cmpLogs("R2 max length");
    hostBurst(16'h0400, 2, 32'hA300_0000, 2);
    idle(20);
    expPkt(8'h21, 2'b00, 16'h0400, 1, 32'hA300_0000, 0);
    expPkt(8'h21, 2'b00, 16'h0402, 1, 32'hA300_0001, 0);
    cmpLogs("R2 address gap");
  endtask

  // R3 R4: foreign packets
  task automatic tRemote();
    rxPacket(8'h05, 2'b00, 16'h0040, 3, 32'hB000_0000);
    idle(3);
    rxPacket(8'h06, 2'b00, 16'h0F00, 5, 32'hB100_0000);
    idle(20);
    expPkt(8'h05, 2'b00, 16'h0040, 3, 32'hB000_0000, 1);
    expPkt(8'h06, 2'b00, 16'h0F00, 5, 32'hB100_0000, 1);
    cmpLogs("R3 R4");
  endtask

  // R5: own packet removal
  task automatic tOwn();
    rxPacket(8'h21, 2'b00, 16'h0050, 2, 32'hC000_0000);
    idle(10);
    expEq("R5", "ownSeen set", 48'(ownSeen), 48'd1);
    cmpLogs("R5 own dropped");
    rxPacket(8'h07, 2'b00, 16'h0058, 1, 32'hC100_0000);
    idle(10);
    expPkt(8'h07, 2'b00, 16'h0058, 1, 32'hC100_0000, 1);
    cmpLogs("R5 next foreign passes");
    expEq("R5", "ownSeen sticky", 48'(ownSeen), 48'd1);
  endtask

  // R6: marker stamping
  task automatic tMark();
    rogueRole = 2'b01;
    rxPacket(8'h05, 2'b00, 16'h0060, 2, 32'hD000_0000);
    idle(5);
    rxPacket(8'h09, 2'b10, 16'h0068, 1, 32'hD100_0000);
    idle(5);
    hostBurst(16'h0070, 1, 32'hD200_0000, 1);
    idle(15);
    expPkt(8'h05, 2'b01, 16'h0060, 2, 32'hD000_0000, 1);
    expPkt(8'h09, 2'b11, 16'h0068, 1, 32'hD100_0000, 1);
    expPkt(8'h21, 2'b01, 16'h0070, 1, 32'hD200_0000, 0);
    cmpLogs("R6");
    expEq("R6", "no fault on other role mark", 48'(rogueFault), 48'd0);
  endtask

  // R7 R8: rogue removal and fault flag
  task automatic tRogue();
    rogueRole = 2'b10;
    irqEn = 1'b1;
    rxPacket(8'h09, 2'b10, 16'h0080, 2, 32'hE000_0000);
    idle(10);
    cmpLogs("R7 rogue dropped");
    expEq("R7", "rogueFault", 48'(rogueFault), 48'd1);
    #1 expEq("R8", "irq enabled", 48'(irq), 48'd1);
    @(negedge clk); rogueClr = 1'b1;
    @(negedge clk); rogueClr = 1'b0;
    expEq("R8", "fault cleared", 48'(rogueFault), 48'd0);
    #1 expEq("R8", "irq after clear", 48'(irq), 48'd0);
    irqEn = 1'b0;
    rxPacket(8'h0A, 2'b11, 16'h0088, 1, 32'hE100_0000);
    idle(6);
    expEq("R7", "fault again", 48'(rogueFault), 48'd1);
    #1 expEq("R8", "irq masked", 48'(irq), 48'd0);
    @(negedge clk); rogueClr = 1'b1;
    @(negedge clk); rogueClr = 1'b0;
    rxPacket(8'h0A, 2'b01, 16'h008C, 2, 32'hE200_0000);
    idle(10);
    expPkt(8'h0A, 2'b11, 16'h008C, 2, 32'hE200_0000, 1);
    cmpLogs("R7 other role passes");
    expEq("R7", "no fault for other role", 48'(rogueFault), 48'd0);
    rogueRole = 2'b00;
  endtask

  // R9: arbitration
  task automatic tPriority();
    fork
      hostBurst(16'h0500, 2, 32'hF000_0000, 1);
      rxPacket(8'h0B, 2'b00, 16'h0090, 3, 32'hF100_0000);
    join
    idle(20);
    expPkt(8'h0B, 2'b00, 16'h0090, 3, 32'hF100_0000, 1);
    expPkt(8'h21, 2'b00, 16'h0500, 2, 32'hF000_0000, 0);
    cmpLogs("R9 forward first");
    fork
      hostBurst(16'h0600, 4, 32'hF200_0000, 1);
      begin idle(2); rxPacket(8'h0C, 2'b00, 16'h00A0, 2, 32'hF300_0000); end
    join
    idle(20);
    expPkt(8'h21, 2'b00, 16'h0600, 4, 32'hF200_0000, 0);
    expPkt(8'h0C, 2'b00, 16'h00A0, 2, 32'hF300_0000, 1);
    cmpLogs("R9 local not interrupted");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tLocal();
    tRemote();
    tOwn();
    tMark();
    tRogue();
    tPriority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule